// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block decides which analog input a 12-input successive-approximation converter samples next. The caller sets a 2-bit scan mode, a 4-bit channel select, a flag that reserves the highest input as a reference pin and a flag for continuous operation, then pulses `start`. The block captures the resulting channel plan at that moment. It then offers one channel index at a time on a valid/ready stream toward the converter.

Each accepted index is one conversion. When the last index of a finite scan has been taken, the block pulses `done`. It also keeps a count of the conversions taken since the scan began. An `abort` input ends any scan at once. In continuous operation this is the only way out.

Stream rules: `conv_valid` and `conv_ch` form the producer side and `conv_ready` is driven by the converter. A transfer happens on a rising clock edge where `conv_valid` and `conv_ready` are both high and `abort` is low. While `conv_valid` is high and no transfer occurs, `conv_ch` is held. The converter may hold `conv_ready` low for any number of cycles.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, `conv_valid`, `busy` and `done` are 0, `conv_ch` is 0 (input AIN0) and `result_count` is 0. The held plan is a single conversion of AIN0 with the top input used as an ordinary analog input.
- R2: Mode 2'b00 issues the channels in ascending order from 0 up to the select value. A select value above 11 is treated as 11.
- R3: When `cfg_ref_top` is 1, channel 11 is never issued in modes 2'b00 and 2'b10, so these scans end at channel 10 or below.
- R4: Mode 2'b01 with `cfg_continuous` at 0 issues the selected channel eight times. In single-channel modes (2'b01, 2'b11), a select value above 11 is treated as 11, and `cfg_ref_top` has no effect.
- R5: Mode 2'b10 issues channels in ascending order from 6 up to the clamped select value. When the select is 6 or lower, only channel 6 is issued.
- R6: Mode 2'b11 with `cfg_continuous` at 0 issues the selected channel once.
- R7: With `cfg_continuous` at 1, modes 2'b01 and 2'b11 both issue the selected channel on every transfer without end, and `done` never pulses.
- R8: While `conv_valid` is high without a transfer, `conv_valid` stays high and `conv_ch` is unchanged. `conv_ch` advances only on a transfer. There is no idle cycle between items, so with `conv_ready` held high an N-item scan raises `done` N cycles after the edge that accepts `start`.
- R9: `done` is high for exactly one cycle, in the cycle right after the final transfer, with `conv_valid` and `busy` low. `busy` and `conv_valid` are high from the cycle after `start` is accepted.
- R10: An edge with `abort` high while running returns the block to idle: after it, `conv_valid`, `busy` and `done` are 0. A handshake on that same edge is not a transfer. `result_count` keeps the number of transfers made before the abort. `start` is not accepted while `abort` is high.
- R11: `result_count` is cleared when a scan is accepted and rises by one per transfer. It saturates at 2^CNT_W-1 (255 by default) and holds after the scan ends.
- R12: The configuration inputs are captured only on the edge that accepts `start`, and only while idle. A `start` pulse or configuration change during a scan has no effect on the channels issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan with the current configuration (accepted only while idle) |
| abort | input | 1 | End the scan in progress immediately |
| cfg_mode | input | 2 | Scan mode: 00 ascending from 0, 01 eight-fold repeat, 10 ascending from 6, 11 single |
| cfg_sel | input | CH_W (4) | Channel select |
| cfg_ref_top | input | 1 | Highest input serves as reference pin and is excluded from ranged scans |
| cfg_continuous | input | 1 | Modes 01/11 repeat the selected channel until abort |
| conv_ready | input | 1 | Converter accepts the offered channel |
| conv_valid | output | 1 | A channel index is offered |
| conv_ch | output | CH_W (4) | Offered channel index |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse after the final transfer of a finite scan |
| result_count | output | CNT_W (8) | Transfers made since the current or last scan began |

## Verification
Each scan mode is driven with select values below, at and above its clamping bounds, with and without the reference flag. The results separate the clamp at 11, the fallback to channel 6 and the exclusion of channel 11. Ready is driven three ways: held high, a pseudo-random pattern and held low. Held high exposes bubbles and off-by-one counting of repeats. The pseudo-random pattern exposes index advance without a handshake. Held low with a start and configuration change mid-scan shows whether the plan is captured only once. Aborts taken with ready low and with ready high distinguish whether the final handshake is counted. A long continuous run distinguishes a saturating count from a wrapping one.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Scan mode encoding as applied on cfg_mode
  typedef enum logic [1:0] {
    MODE_FROM_ZERO = 2'b00,
    MODE_REPEAT    = 2'b01,
    MODE_FROM_MID  = 2'b10,
    MODE_SINGLE    = 2'b11
  } scan_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } step_state_e;

endpackage

// File: rtl/scan_range.sv
// Turns the raw configuration into a channel plan: first and last index,
// issues per index minus one, and whether the plan loops forever.
module scan_range
  import scan_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int CH_W     = 4,
  parameter int MID_CH   = 6,
  parameter int REPEAT_N = 8,
  parameter int REP_W    = 3
) (
  input  logic [1:0]       mode,
  input  logic [CH_W-1:0]  sel,
  input  logic             ref_top,
  input  logic             continuous,
  output logic [CH_W-1:0]  first_ch,
  output logic [CH_W-1:0]  last_ch,
  output logic [REP_W-1:0] reps_m1,
  output logic             forever_run
);

  localparam logic [CH_W-1:0]  TOP_CH   = CH_W'(NUM_CH - 1);
  localparam logic [CH_W-1:0]  MID_IDX  = CH_W'(MID_CH);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEAT_N - 1);

  logic [CH_W-1:0] clamped;
  logic [CH_W-1:0] scan_ceiling;
  logic [CH_W-1:0] ranged_end;
  scan_mode_e      mode_e;

  assign mode_e       = scan_mode_e'(mode);
  assign clamped      = (sel > TOP_CH) ? TOP_CH : sel;
  // reference pin drops out of ranged scans only
  assign scan_ceiling = ref_top ? (TOP_CH - 1'b1) : TOP_CH;
  assign ranged_end   = (clamped > scan_ceiling) ? scan_ceiling : clamped;

  always_comb begin
    first_ch    = '0;
    last_ch     = '0;
    reps_m1     = '0;
    forever_run = 1'b0;
    unique case (mode_e)
      MODE_FROM_ZERO: begin
        first_ch = '0;
        last_ch  = ranged_end;
      end
      MODE_REPEAT: begin
        first_ch    = clamped;
        last_ch     = clamped;
        reps_m1     = continuous ? '0 : REP_LAST;
        forever_run = continuous;
      end
      MODE_FROM_MID: begin
        first_ch = MID_IDX;
        last_ch  = (ranged_end < MID_IDX) ? MID_IDX : ranged_end;
      end
      MODE_SINGLE: begin
        first_ch    = clamped;
        last_ch     = clamped;
        forever_run = continuous;
      end
      default: begin
        first_ch = '0;
        last_ch  = '0;
      end
    endcase
  end

endmodule

// File: rtl/scan_stepper.sv
// Holds the captured plan and walks it one transfer at a time.
module scan_stepper
  import scan_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int REP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CH_W-1:0]  plan_first,
  input  logic [CH_W-1:0]  plan_last,
  input  logic [REP_W-1:0] plan_reps_m1,
  input  logic             plan_forever,
  input  logic             conv_ready,
  output logic             conv_valid,
  output logic [CH_W-1:0]  conv_ch,
  output logic             busy,
  output logic             done,
  output logic             start_taken,
  output logic             xfer
);

  step_state_e      state_q;
  logic [CH_W-1:0]  first_q;
  logic [CH_W-1:0]  last_q;
  logic [REP_W-1:0] reps_m1_q;
  logic             forever_q;
  logic [CH_W-1:0]  cur_q;
  logic [REP_W-1:0] rep_q;
  logic             done_q;

  logic running;
  logic rep_final;
  logic ch_final;

  assign running     = (state_q == ST_RUN);
  assign start_taken = start && !abort && !running;
  assign xfer        = running && conv_ready && !abort;
  assign rep_final   = (rep_q == reps_m1_q);
  assign ch_final    = (cur_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      first_q   <= '0;
      last_q    <= '0;
      reps_m1_q <= '0;
      forever_q <= 1'b0;
      cur_q     <= '0;
      rep_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!running) begin
        if (start_taken) begin
          first_q   <= plan_first;
          last_q    <= plan_last;
          reps_m1_q <= plan_reps_m1;
          forever_q <= plan_forever;
          cur_q     <= plan_first;
          rep_q     <= '0;
          state_q   <= ST_RUN;
        end
      end else if (abort) begin
        state_q <= ST_IDLE;
      end else if (conv_ready) begin
        if (!rep_final) begin
          rep_q <= rep_q + 1'b1;
        end else begin
          rep_q <= '0;
          if (!ch_final) begin
            cur_q <= cur_q + 1'b1;
          end else if (!forever_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign conv_valid = running;
  assign conv_ch    = cur_q;
  assign busy       = running;
  assign done       = done_q;

  // R8: offered index held under back-pressure
  p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !conv_ready && !abort) |=> (conv_valid && $stable(conv_ch)));

  // R10: abort empties the stream without a completion pulse
  p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && abort) |=> (!conv_valid && !done));

  // R9: completion follows a handshake and leaves the stream idle
  p_done_after_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!conv_valid && $past(conv_valid && conv_ready && !abort)));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: offered index stays within the captured plan
  p_index_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> (conv_ch >= first_q && conv_ch <= last_q));

  // R12: captured plan is frozen during a scan
  p_plan_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !abort && !done_q) |=> ($stable(first_q) && $stable(last_q)));

endmodule

// File: rtl/scan_count.sv
// Saturating count of conversions taken in the current scan.
module scan_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (inc && (count_q != CNT_MAX)) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;

  // R11: each transfer below the ceiling adds exactly one
  p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && inc && count != CNT_MAX) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R11: no transfer, or at the ceiling, leaves the count alone
  p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && (!inc || count == CNT_MAX)) |=> $stable(count));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int CH_W     = 4,
  parameter int MID_CH   = 6,
  parameter int REPEAT_N = 8,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [1:0]       cfg_mode,
  input  logic [CH_W-1:0]  cfg_sel,
  input  logic             cfg_ref_top,
  input  logic             cfg_continuous,
  input  logic             conv_ready,
  output logic             conv_valid,
  output logic [CH_W-1:0]  conv_ch,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] result_count
);

  localparam int REP_W = (REPEAT_N > 1) ? $clog2(REPEAT_N) : 1;

  logic [CH_W-1:0]  plan_first;
  logic [CH_W-1:0]  plan_last;
  logic [REP_W-1:0] plan_reps_m1;
  logic             plan_forever;
  logic             start_taken;
  logic             xfer;

  scan_range #(
    .NUM_CH  (NUM_CH),
    .CH_W    (CH_W),
    .MID_CH  (MID_CH),
    .REPEAT_N(REPEAT_N),
    .REP_W   (REP_W)
  ) u_range (
    .mode       (cfg_mode),
    .sel        (cfg_sel),
    .ref_top    (cfg_ref_top),
    .continuous (cfg_continuous),
    .first_ch   (plan_first),
    .last_ch    (plan_last),
    .reps_m1    (plan_reps_m1),
    .forever_run(plan_forever)
  );

  scan_stepper #(
    .CH_W (CH_W),
    .REP_W(REP_W)
  ) u_stepper (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .abort       (abort),
    .plan_first  (plan_first),
    .plan_last   (plan_last),
    .plan_reps_m1(plan_reps_m1),
    .plan_forever(plan_forever),
    .conv_ready  (conv_ready),
    .conv_valid  (conv_valid),
    .conv_ch     (conv_ch),
    .busy        (busy),
    .done        (done),
    .start_taken (start_taken),
    .xfer        (xfer)
  );

  scan_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(start_taken),
    .inc  (xfer),
    .count(result_count)
  );

  // R9: an accepted start puts an index on the stream next cycle
  p_start_offers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !busy) |=> (conv_valid && busy && result_count == '0));

  // R12: a start while running changes nothing on the stream
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !abort && !conv_ready) |=> $stable(conv_ch));

endmodule

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;

  localparam int CH_W  = 4;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             abort = 1'b0;
  logic [1:0]       cfg_mode = 2'b00;
  logic [CH_W-1:0]  cfg_sel = '0;
  logic             cfg_ref_top = 1'b0;
  logic             cfg_continuous = 1'b0;
  logic             conv_ready = 1'b0;
  logic             conv_valid;
  logic [CH_W-1:0]  conv_ch;
  logic             busy;
  logic             done;
  logic [CNT_W-1:0] result_count;

  scan_sequencer dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .abort         (abort),
    .cfg_mode      (cfg_mode),
    .cfg_sel       (cfg_sel),
    .cfg_ref_top   (cfg_ref_top),
    .cfg_continuous(cfg_continuous),
    .conv_ready    (conv_ready),
    .conv_valid    (conv_valid),
    .conv_ch       (conv_ch),
    .busy          (busy),
    .done          (done),
    .result_count  (result_count)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    xfer_cnt = 0;
  int    last_xfer_cyc = 0;
  int    rdy_mode = 2;      // 0 always high, 1 pattern, 2 low
  logic [7:0] lfsr = 8'hA5;
  string cur_req = "R1";
  int    exp_q[$];
  bit    finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // ready generator, updated shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rdy_mode)
        0: conv_ready = 1'b1;
        1: conv_ready = lfsr[0] | lfsr[3];
        default: conv_ready = 1'b0;
      endcase
    end
  end

  // monitor: every transfer is compared with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && conv_valid && conv_ready && !abort) begin
      xfer_cnt++;
      last_xfer_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected channel", int'(conv_ch), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(conv_ch) == e, cur_req, "channel order", int'(conv_ch), e);
      end
    end
  end

  // expected channel list, built from the requirements
  task automatic push_plan(input int mode, input int sel, input bit reftop,
                           output int n);
    int s;
    int last;
    s = (sel > 11) ? 11 : sel;
    n = 0;
    case (mode)
      0: begin
        last = s;
        if (reftop && last > 10) last = 10;
        for (int c = 0; c <= last; c++) begin exp_q.push_back(c); n++; end
      end
      1: for (int k = 0; k < 8; k++) begin exp_q.push_back(s); n++; end
      2: begin
        last = (s < 6) ? 6 : s;
        if (reftop && last > 10) last = 10;
        for (int c = 6; c <= last; c++) begin exp_q.push_back(c); n++; end
      end
      default: begin exp_q.push_back(s); n++; end
    endcase
  endtask

  int accept_cyc = 0;

  task automatic kick(input int mode, input int sel, input bit reftop, input bit cont);
    @(posedge clk); #1;
    cfg_mode = 2'(mode);
    cfg_sel = 4'(sel);
    cfg_ref_top = reftop;
    cfg_continuous = cont;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    accept_cyc = cyc;
    check(busy == 1'b1 && conv_valid == 1'b1, "R9", "busy/valid after start",
          {busy, conv_valid}, 3);
    check(result_count == 0, "R11", "count cleared at start", int'(result_count), 0);
  endtask

  task automatic finish_scan(input int n, input bit tight);
    int guard;
    guard = 0;
    @(negedge clk);
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check(done == 1'b1, cur_req, "done seen", done, 1);
    check(cyc == last_xfer_cyc + 1, "R9", "done one cycle after final transfer",
          cyc, last_xfer_cyc + 1);
    check(conv_valid == 1'b0 && busy == 1'b0, "R9", "idle with done",
          {conv_valid, busy}, 0);
    check(exp_q.size() == 0, cur_req, "items left over", exp_q.size(), 0);
    check(int'(result_count) == n, "R11", "count at end", int'(result_count), n);
    if (tight)
      check(cyc - accept_cyc == n, "R8", "no bubble with ready high",
            cyc - accept_cyc, n);
    @(negedge clk);
    check(done == 1'b0, "R9", "done pulse width", done, 0);
    check(int'(result_count) == n, "R11", "count holds after scan",
          int'(result_count), n);
  endtask

  task automatic run_scan(input string req, input int mode, input int sel,
                          input bit reftop, input int rm);
    int n;
    cur_req = req;
    rdy_mode = rm;
    push_plan(mode, sel, reftop, n);
    kick(mode, sel, reftop, 1'b0);
    finish_scan(n, rm == 0);
    rdy_mode = 2;
  endtask

  // abort after k transfers; hold_ready keeps ready high on the abort edge
  task automatic abort_after(input string req, input int base, input int k,
                             input bit hold_ready);
    wait (xfer_cnt == base + k);
    @(posedge clk); #1;
    if (!hold_ready) begin
      rdy_mode = 2;
      conv_ready = 1'b0;
    end
    abort = 1'b1;
    @(posedge clk); #1;
    abort = 1'b0;
    rdy_mode = 2;
    check(conv_valid == 1'b0 && busy == 1'b0, "R10", "idle after abort",
          {conv_valid, busy}, 0);
    check(done == 1'b0, "R10", "no done on abort", done, 0);
    check(int'(result_count) == k, req, "count after abort", int'(result_count), k);
    exp_q.delete();
    @(negedge clk);
  endtask

  initial begin
    begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "WD", "watchdog expired", cyc, 0);
      finish_sim();
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check(conv_valid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1",
          "outputs idle in reset", {conv_valid, busy, done}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(conv_ch == 0, "R1", "channel after reset", int'(conv_ch), 0);
    check(result_count == 0, "R1", "count after reset", int'(result_count), 0);

    // R2: ascending from zero, in range and clamped
    run_scan("R2", 0, 5, 1'b0, 0);
    run_scan("R2", 0, 14, 1'b0, 1);
    run_scan("R2", 0, 0, 1'b0, 0);
    // R3: reference pin excluded
    run_scan("R3", 0, 15, 1'b1, 1);
    run_scan("R3", 2, 11, 1'b1, 0);
    run_scan("R3", 0, 9, 1'b1, 1);
    // R4: eight-fold repeat, clamped select, ref flag ignored
    run_scan("R4", 1, 3, 1'b0, 1);
    run_scan("R4", 1, 13, 1'b1, 0);
    // R5: ascending from six, fallback and clamp
    run_scan("R5", 2, 9, 1'b0, 1);
    run_scan("R5", 2, 2, 1'b0, 0);
    run_scan("R5", 2, 15, 1'b0, 1);
    // R6: single conversion
    run_scan("R6", 3, 7, 1'b0, 0);
    run_scan("R6", 3, 11, 1'b1, 1);

    // R7: continuous single-channel modes, ended by abort
    cur_req = "R7";
    base = xfer_cnt;
    for (int k = 0; k < 10; k++) exp_q.push_back(5);
    rdy_mode = 1;
    kick(3, 5, 1'b0, 1'b1);
    abort_after("R7", base, 10, 1'b0);
    base = xfer_cnt;
    for (int k = 0; k < 12; k++) exp_q.push_back(9);
    rdy_mode = 0;
    kick(1, 9, 1'b0, 1'b1);
    abort_after("R7", base, 12, 1'b0);

    // R11: saturation during a long continuous run
    cur_req = "R11";
    base = xfer_cnt;
    for (int k = 0; k < 300; k++) exp_q.push_back(2);
    rdy_mode = 0;
    kick(1, 2, 1'b0, 1'b1);
    wait (xfer_cnt == base + 300);
    @(posedge clk); #1;
    rdy_mode = 2; conv_ready = 1'b0; abort = 1'b1;
    @(posedge clk); #1;
    abort = 1'b0;
    check(int'(result_count) == 255, "R11", "saturated count",
          int'(result_count), 255);
    cfg_continuous = 1'b0;

    // R10: abort mid-scan with ready low, then with ready high on the edge
    cur_req = "R10";
    base = xfer_cnt;
    begin int n; push_plan(0, 11, 1'b0, n); end
    rdy_mode = 1;
    kick(0, 11, 1'b0, 1'b0);
    abort_after("R10", base, 4, 1'b0);
    base = xfer_cnt;
    begin int n; push_plan(0, 11, 1'b0, n); end
    rdy_mode = 0;
    kick(0, 11, 1'b0, 1'b0);
    abort_after("R10", base, 3, 1'b1);
    // R10: start together with abort while idle is not taken
    @(posedge clk); #1;
    start = 1'b1; abort = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; abort = 1'b0;
    check(busy == 1'b0 && conv_valid == 1'b0, "R10", "start blocked by abort",
          {busy, conv_valid}, 0);

    // R12 and R8: back-pressure, then a start and new config mid-scan
    cur_req = "R12";
    begin int n; push_plan(0, 3, 1'b0, n); end
    rdy_mode = 2;
    kick(0, 3, 1'b0, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check(conv_valid == 1'b1 && conv_ch == 0, "R8", "held under back-pressure",
            int'(conv_ch), 0);
    end
    @(posedge clk); #1;
    cfg_mode = 2'b11; cfg_sel = 4'd9; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check(conv_ch == 0, "R12", "start while busy ignored", int'(conv_ch), 0);
    rdy_mode = 1;
    finish_scan(4, 1'b0);
    rdy_mode = 2;

    repeat (3) @(posedge clk);
    finish_sim();
  end

endmodule